// File: doc/BRIEF.md
# Write-Protect Guard and Status Byte

This block sits behind the command decoder of a small serial non-volatile memory. It holds the write-enable latch and the two protect-code bits, and it builds the byte returned by a status read. From these it decides, cycle by cycle, whether a status-register write may begin and whether an array write to the presented address may begin.

The decoder feeds it single-cycle events: set latch, clear latch, status write (with the written byte), and write done (end of any internal write cycle). It also receives the busy flag and the active-low hardware protect pin. A status write that is accepted is held pending and takes effect when the internal write finishes, so dropping the protect pin during that write does not cancel it. The protect code has no reset. It is loaded from an initial value by `init_load` and afterwards only by a committed status write.

Top module: `wp_status_guard`

## Requirements
- R1: `status_byte` is {4'b0000, protect code, latch, busy}. Bits 7..4 are 0, bits 3..2 hold the protect code, bit 1 holds the write-enable latch and bit 0 follows `busy` in the same cycle, whether or not a write is running.
- R2: Protect code 2'b00 blocks no address. 2'b01 blocks 0x180..0x1FF. 2'b10 blocks 0x100..0x1FF. 2'b11 blocks every address. `arr_wr_ok` is 0 for a blocked address.
- R3: With `wp_n` high, `cmd_wren` sets the latch at the next edge when no clear reason is present that cycle. This holds even while the status register is write-protected.
- R4: With `wp_n` high, `cmd_wrdi` or `wr_done` clears the latch at the next edge. Both win over `cmd_wren` raised in the same cycle.
- R5: While `wp_n` is low, the latch clears at the next edge, and `stat_wr_ok` and `arr_wr_ok` are both 0.
- R6: While the latch is clear, `stat_wr_ok` and `arr_wr_ok` are 0.
- R7: `cmd_stat_wr` is accepted only when `stat_wr_ok` is 1. Only bits 3..2 of `stat_wdata` are kept. They appear in the status byte at the edge that samples the next `wr_done`. Before that edge the protect code does not change.
- R8: If `wp_n` goes low after a status write has been accepted, the pending code is still committed at `wr_done`.
- R9: Reset clears the latch and discards any pending status write. `init_load` copies `init_bp` into the protect code.
- R10: While `busy` is 1, `stat_wr_ok` and `arr_wr_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| init_load | input | 1 | Load protect code from `init_bp` |
| init_bp | input | 2 | Initial protect code |
| cmd_wren | input | 1 | Set-latch event |
| cmd_wrdi | input | 1 | Clear-latch event |
| cmd_stat_wr | input | 1 | Status-write event |
| stat_wdata | input | 8 | Byte carried by the status write |
| wr_done | input | 1 | Internal write cycle finished |
| busy | input | 1 | Internal write running |
| wp_n | input | 1 | Hardware protect pin, low protects |
| addr | input | 9 | Target array address |
| status_byte | output | 8 | Readable status byte |
| stat_wr_ok | output | 1 | Status write may start |
| arr_wr_ok | output | 1 | Array write to `addr` may start |

## Verification
Two pairs of functions can land in the same cycle, and the bench forces both. In the first pair, a latch-set event arrives together with a clear reason (`wr_done`, `cmd_wrdi` or a low pin); the latch must read 0 after the edge. In the second pair, a pending status write completes while the pin is low; the committed protect code must appear even though the latch clears. These cases are driven both on purpose and through a random mix of events. Each cycle is judged against a reference model kept in the bench.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int BP_W = 2;
  localparam int STAT_W = 8;
  localparam int STAT_WIP = 0;
  localparam int STAT_WEL = 1;
  localparam int STAT_BP_LO = 2;
  localparam int STAT_BP_HI = STAT_BP_LO + BP_W - 1;

  typedef enum logic [BP_W-1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_code_t;
endpackage

// File: rtl/wpg_rst_sync.sv
module wpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/wpg_wel_latch.sv
module wpg_wel_latch (
  input  logic clk,
  input  logic rst_s,
  input  logic wp_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic done_ev,
  output logic wel
);
  logic wel_q, wel_d, wel_en;

  always_comb begin
    wel_en = 1'b1;
    if (!wp_n)        wel_d = 1'b0;
    else if (done_ev) wel_d = 1'b0;
    else if (clr_ev)  wel_d = 1'b0;
    else if (set_ev)  wel_d = 1'b1;
    else begin
      wel_d  = wel_q;
      wel_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel = wel_q;
endmodule

// File: rtl/wpg_bp_store.sv
module wpg_bp_store
  import wpg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_s,
  input  logic            init_load,
  input  logic [BP_W-1:0] init_bp,
  input  logic            accept,
  input  logic [BP_W-1:0] new_bp,
  input  logic            done_ev,
  output logic [BP_W-1:0] bp
);
  logic [BP_W-1:0] bp_q, bp_d, pbp_q, pbp_d;
  logic            bp_en, pend_q, pend_d, pend_en;

  always_comb begin
    bp_en   = 1'b0;
    bp_d    = bp_q;
    pend_d  = pend_q;
    pbp_d   = pbp_q;
    pend_en = 1'b0;
    if (init_load) begin
      bp_en = 1'b1;
      bp_d  = init_bp;
    end else if (done_ev && pend_q) begin
      bp_en = 1'b1;
      bp_d  = pbp_q;
    end
    if (done_ev) begin
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end
    if (accept) begin
      pend_d  = 1'b1;
      pbp_d   = new_bp;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bp_en) bp_q <= bp_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q <= 1'b0;
      pbp_q  <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      pbp_q  <= pbp_d;
    end
  end

  assign bp = bp_q;
endmodule

// File: rtl/wpg_region_check.sv
module wpg_region_check
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [BP_W-1:0]   code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb begin
    case (prot_code_t'(code))
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = &addr[ADDR_W-1:ADDR_W-2];
      PROT_HALF: hit = addr[ADDR_W-1];
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic [1:0]        init_bp,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              wr_done,
  input  logic              busy,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_byte,
  output logic              stat_wr_ok,
  output logic              arr_wr_ok
);
  logic            rst_s, wel, hit, unused_bits;
  logic [BP_W-1:0] bp;

  assign unused_bits = ^{stat_wdata[7:STAT_BP_HI+1], stat_wdata[STAT_BP_LO-1:0]};

  wpg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  wpg_wel_latch u_wel (
    .clk(clk), .rst_s(rst_s), .wp_n(wp_n), .set_ev(cmd_wren),
    .clr_ev(cmd_wrdi), .done_ev(wr_done), .wel(wel)
  );

  assign stat_wr_ok = wp_n & wel & ~busy;

  wpg_bp_store u_bp (
    .clk(clk), .rst_s(rst_s), .init_load(init_load), .init_bp(init_bp),
    .accept(cmd_stat_wr & stat_wr_ok), .new_bp(stat_wdata[STAT_BP_HI:STAT_BP_LO]),
    .done_ev(wr_done), .bp(bp)
  );

  wpg_region_check #(.ADDR_W(ADDR_W)) u_rgn (
    .code(bp), .addr(addr), .hit(hit)
  );

  assign arr_wr_ok = stat_wr_ok & ~hit;

  always_comb begin
    status_byte = '0;
    status_byte[STAT_BP_HI:STAT_BP_LO] = bp;
    status_byte[STAT_WEL] = wel;
    status_byte[STAT_WIP] = busy;
  end
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic       clk,
  input logic       rst_s,
  input logic       init_load,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       wr_done,
  input logic       busy,
  input logic       wp_n,
  input logic [7:0] status_byte,
  input logic       stat_wr_ok,
  input logic       arr_wr_ok
);
  assert_layout_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (status_byte[7:4] == 4'h0) && (status_byte[0] == busy));

  assert_full_block_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (status_byte[3:2] == 2'b11) |-> !arr_wr_ok);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (wp_n && cmd_wren && !cmd_wrdi && !wr_done) |=> status_byte[1]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_wrdi || wr_done) |=> !status_byte[1]);

  assert_pin_clear_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !wp_n |=> !status_byte[1]);

  assert_pin_block_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !wp_n |-> (!stat_wr_ok && !arr_wr_ok));

  assert_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !status_byte[1] |-> (!stat_wr_ok && !arr_wr_ok));

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (!wr_done && !init_load) |=> $stable(status_byte[3:2]));

  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> (!stat_wr_ok && !arr_wr_ok));
endmodule

bind wp_status_guard wpg_checker u_chk (
  .clk(clk), .rst_s(rst_s), .init_load(init_load), .cmd_wren(cmd_wren),
  .cmd_wrdi(cmd_wrdi), .wr_done(wr_done), .busy(busy), .wp_n(wp_n),
  .status_byte(status_byte), .stat_wr_ok(stat_wr_ok), .arr_wr_ok(arr_wr_ok)
);

// File: tb/test_wp_status_guard.sv
`timescale 1ns/1ps
module test_wp_status_guard;
  logic       clk = 1'b0;
  logic       rst_n, init_load, cmd_wren, cmd_wrdi, cmd_stat_wr, wr_done, busy, wp_n;
  logic [1:0] init_bp;
  logic [7:0] stat_wdata, status_byte;
  logic [8:0] addr;
  logic       stat_wr_ok, arr_wr_ok;

  int n_chk = 0, n_bad = 0;
  logic       m_wel, m_pend;
  logic [1:0] m_bp, m_pbp;

  always #2 clk = ~clk;

  wp_status_guard i_wp_status_guard (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_bp(init_bp),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_stat_wr(cmd_stat_wr),
    .stat_wdata(stat_wdata), .wr_done(wr_done), .busy(busy), .wp_n(wp_n),
    .addr(addr), .status_byte(status_byte), .stat_wr_ok(stat_wr_ok),
    .arr_wr_ok(arr_wr_ok)
  );

  function automatic logic blocked(logic [1:0] code, logic [8:0] a);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cmd_wren = 0; cmd_wrdi = 0; cmd_stat_wr = 0; wr_done = 0; busy = 0;
    wp_n = 1; init_load = 0; stat_wdata = 0; addr = 0; init_bp = 0;
  endtask

  task automatic step(string tag, logic wren, logic wrdi, logic sw, logic [7:0] wd,
                      logic done, logic bsy, logic wp, logic [8:0] a);
    logic sok, aok;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_stat_wr = sw; stat_wdata = wd;
    wr_done = done; busy = bsy; wp_n = wp; addr = a;
    #1;
    sok = wp & m_wel & ~bsy;
    aok = sok & ~blocked(m_bp, a);
    check({tag, " stat_wr_ok"}, {7'b0, stat_wr_ok}, {7'b0, sok});
    check({tag, " arr_wr_ok"},  {7'b0, arr_wr_ok},  {7'b0, aok});
    @(posedge clk);
    #1;
    if (done) begin
      if (m_pend) m_bp = m_pbp;
      m_pend = 0;
    end
    if (sw && sok) begin
      m_pend = 1;
      m_pbp  = wd[3:2];
    end
    if (!wp)        m_wel = 0;
    else if (done)  m_wel = 0;
    else if (wrdi)  m_wel = 0;
    else if (wren)  m_wel = 1;
    check({tag, " status"}, status_byte, {4'b0, m_bp, m_wel, bsy});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_wel = 0; m_pend = 0;
  endtask

  task automatic set_code(logic [1:0] c);
    step("R3", 1, 0, 0, 8'h00, 0, 0, 1, 9'h0);
    step("R7", 0, 0, 1, {4'hF, c, 2'b11}, 0, 0, 1, 9'h0);
    step("R7", 0, 0, 0, 8'h00, 0, 1, 1, 9'h0);
    step("R7", 0, 0, 0, 8'h00, 1, 1, 1, 9'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    idle();
    rst_n = 0;
    m_wel = 0; m_pend = 0; m_bp = 2'b10; m_pbp = 0;
    do_reset();
    // R9: initial load of the protect code, latch clear after reset
    init_bp = 2'b10; init_load = 1;
    @(negedge clk); init_load = 0; #1;
    check("R9 reset state", status_byte, 8'b0000_1000);
    // R2 boundaries for every code
    set_code(2'b01);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 9'h17F);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 9'h180);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 9'h1FF);
    set_code(2'b10);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 9'h0FF);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 9'h100);
    set_code(2'b00);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 9'h1FF);
    set_code(2'b11);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 9'h000);
    // R4: set together with each clear reason
    step("R4", 1, 0, 0, 0, 1, 0, 1, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0);
    step("R4", 1, 1, 0, 0, 0, 0, 1, 0);
    step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
    // R6: latch clear blocks everything
    step("R6", 0, 0, 1, 8'h00, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 0, 1, 0, 1, 0);
    // R8: pin drops during a running status write
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 1, 8'h04, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 1, 0, 0);
    // R10: busy blocks and shows in bit 0
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0);
    step("R10", 0, 0, 1, 8'h0C, 0, 1, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 0, 1, 0);
    // R9: reset discards a pending status write
    step("R3", 1, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 1, 8'h08, 0, 0, 1, 0);
    do_reset();
    step("R9", 0, 0, 0, 0, 1, 0, 1, 0);
    // random mix, R1 layout and all rules via the model
    for (int i = 0; i < 3000; i++) begin
      step("R1 random",
           ($urandom % 4) == 0, ($urandom % 12) == 0, ($urandom % 5) == 0,
           8'($urandom), ($urandom % 10) == 0, ($urandom % 5) == 0,
           ($urandom % 12) != 0, 9'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule